// File: doc/BRIEF.md
# Unaligned Access Splitter

This block sits between a load/store unit and a memory bus that only accepts naturally aligned transfers. It takes one request at a time (address, size, direction, write data and a flag marking the private peripheral region) and turns it into one, two or three aligned bus transfers. These transfers are issued in ascending byte order. For stores, each transfer carries the right request bytes on its own byte lanes with a matching strobe mask. For loads, the bytes returned by each transfer are gathered into one little-endian result.

A request that may not be split is rejected with a fault and never reaches the bus. The two cases are an unaligned access to the private peripheral region and a paired (two-word) access that is not word aligned. A bus error on any transfer ends the request with a fault.

The parameter `WRAP_EN` selects one of two port variants:
- With `WRAP_EN` set, the continuation of an access that crosses the top of a region wraps within the low `WRAP_BITS` address bits, back to the region base.
- With `WRAP_EN` clear, the address simply keeps counting past the region limit.

Top module: `uas_splitter`

## Requirements
- R1: A byte request, a halfword request at an even address, a word request at offset 0 and a word-aligned pair request are issued without further splitting. Byte, halfword and word requests become exactly one transfer of the request size. A pair becomes two word transfers. Size codes are 0 byte, 1 halfword, 2 word, 3 pair; the bus uses codes 0 to 2.
- R2: Every bus transfer is naturally aligned: a word transfer has address bits [1:0] equal to 0, and a halfword transfer has address bit 0 equal to 0.
- R3: A halfword at an odd address becomes two byte transfers: first the addressed byte, then the following byte address.
- R4: A word at offset 2 becomes two halfwords. A word at offset 1 or 3 becomes byte, halfword, byte, at consecutive ascending byte addresses.
- R5: A pair request with address bits [1:0] not 0 ends with done and fault one cycle after acceptance, and no bus transfer is issued. A word-aligned pair request is issued as two word transfers, at the address and then 4 bytes further on.
- R6: When the private peripheral flag is set, an unaligned halfword or word request is rejected with done and fault and no bus transfer. Aligned requests with the flag set proceed normally.
- R7: With WRAP_EN set, each following transfer address keeps address bits above WRAP_BITS unchanged and adds to the low WRAP_BITS bits modulo 2^WRAP_BITS. For example, a halfword at 0x1FFFFFFF is issued as bytes at 0x1FFFFFFF and then 0x00000000.
- R8: With WRAP_EN clear, each following transfer address is the previous one plus its size, modulo 2^ADDR_W. This applies even across a region limit: 0xDFFFFFFF continues to 0xE0000000, 0xFFFFFFFF continues to 0x00000000, and 0x21FFFFFF continues to 0x22000000.
- R9: For a store transfer, the strobe has one bit set per transfer byte, starting at lane address[1:0]. Lane address[1:0]+j carries request byte (bytes already issued + j).
- R10: For a load, rsp_rdata byte k holds the byte read from the k-th byte address of the request, and the bytes above the request size are 0. rsp_done is a single-cycle pulse, given one cycle after the last transfer is acknowledged.
- R11: A bus error reported with an acknowledge ends the request. One cycle later, rsp_done and rsp_fault are high and no further transfer is requested.
- R12: bus_req stays high, with address, size and write data held, until it is acknowledged. req_ready is low while a transfer is pending and in the response cycle.
- R13: After reset, req_ready is high and bus_req and rsp_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 pair |
| req_priv | input | 1 | Request targets the private peripheral region |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | 64 | Store data, little-endian, byte 0 in bits [7:0] |
| rsp_done | output | 1 | Single-cycle completion pulse |
| rsp_fault | output | 1 | Request was rejected or hit a bus error, valid with rsp_done |
| rsp_rdata | output | 64 | Merged load data, valid with rsp_done |
| bus_req | output | 1 | Transfer request |
| bus_ack | input | 1 | Transfer accepted and completed |
| bus_err | input | 1 | Transfer failed, valid with bus_ack |
| bus_write | output | 1 | Transfer direction |
| bus_size | output | 2 | Transfer size, 0 byte, 1 halfword, 2 word |
| bus_addr | output | ADDR_W | Aligned transfer address |
| bus_wdata | output | 32 | Write data on byte lanes |
| bus_strb | output | 4 | Byte-lane strobes |
| bus_rdata | input | 32 | Read data on byte lanes |

## Verification
Two instances are driven, one per port variant. Directed requests sit exactly on the region tops 0x1FFFFFFF, 0xDFFFFFFF, 0xFFFFFFFF and 0x21FFFFFF, and the same request on each variant shows whether the continuation wrapped or ran on. Random requests cover every size and low-address offset, which separates the one-, two- and three-transfer split patterns and the lane steering of each piece. A random acknowledge delay shows that a transfer is held stable while it waits. Rejection is probed with misaligned pairs and with private peripheral requests, both aligned and not, and bus errors are injected on first, middle and last pieces to show that the sequence stops early.

// File: rtl/uas_pkg.sv
package uas_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_PAIR = 2'd3
   } xfer_size_e;

   localparam int unsigned MAX_PARTS  = 3;
   localparam int unsigned BUS_BYTES  = 4;
   localparam int unsigned REQ_BYTES  = 8;
   localparam int unsigned BUS_DW     = BUS_BYTES * 8;
   localparam int unsigned REQ_DW     = REQ_BYTES * 8;
endpackage

// File: rtl/uas_planner.sv
module uas_planner
   import uas_pkg::*;
(
   input  xfer_size_e                    size_i,
   input  logic [1:0]                    off_i,
   input  logic                          priv_i,
   output logic                          illegal_o,
   output logic [1:0]                    nparts_o,
   output logic [MAX_PARTS-1:0][1:0]     part_sz_o
);
   always_comb begin
      illegal_o = 1'b0;
      nparts_o  = 2'd1;
      part_sz_o = '0;
      unique case (size_i)
         SZ_BYTE: part_sz_o[0] = SZ_BYTE;
         SZ_HALF: begin
            if (!off_i[0]) begin
               part_sz_o[0] = SZ_HALF;
            end else begin
               nparts_o     = 2'd2;
               part_sz_o[0] = SZ_BYTE;
               part_sz_o[1] = SZ_BYTE;
               illegal_o    = priv_i;
            end
         end
         SZ_WORD: begin
            illegal_o = priv_i && (off_i != 2'd0);
            unique case (off_i)
               2'd0: part_sz_o[0] = SZ_WORD;
               2'd2: begin
                  nparts_o     = 2'd2;
                  part_sz_o[0] = SZ_HALF;
                  part_sz_o[1] = SZ_HALF;
               end
               default: begin
                  nparts_o     = 2'd3;
                  part_sz_o[0] = SZ_BYTE;
                  part_sz_o[1] = SZ_HALF;
                  part_sz_o[2] = SZ_BYTE;
               end
            endcase
         end
         default: begin
            nparts_o     = 2'd2;
            part_sz_o[0] = SZ_WORD;
            part_sz_o[1] = SZ_WORD;
            illegal_o    = (off_i != 2'd0);
         end
      endcase
   end
endmodule

// File: rtl/uas_addr_step.sv
module uas_addr_step #(
   parameter int unsigned ADDR_W    = 32,
   parameter bit          WRAP_EN   = 1'b0,
   parameter int unsigned WRAP_BITS = 29
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        sz_i,
   output logic [ADDR_W-1:0] next_o
);
   logic [3:0] incr;
   assign incr = 4'd1 << sz_i;

   if (WRAP_EN) begin : g_wrap
      logic [WRAP_BITS-1:0] low_sum;
      assign low_sum = addr_i[WRAP_BITS-1:0] + WRAP_BITS'(incr);
      if (WRAP_BITS == ADDR_W) begin : g_full
         assign next_o = low_sum;
      end else begin : g_part
         assign next_o = {addr_i[ADDR_W-1:WRAP_BITS], low_sum};
      end
   end else begin : g_flat
      assign next_o = addr_i + ADDR_W'(incr);
   end
endmodule

// File: rtl/uas_lane_steer.sv
module uas_lane_steer
   import uas_pkg::*;
(
   input  logic [1:0]        lane_i,
   input  logic [1:0]        sz_i,
   input  logic [2:0]        done_bytes_i,
   input  logic [REQ_DW-1:0] wdata_i,
   input  logic [BUS_DW-1:0] rdata_i,
   input  logic [REQ_DW-1:0] acc_i,
   output logic [BUS_DW-1:0] wdata_o,
   output logic [BUS_BYTES-1:0] strb_o,
   output logic [REQ_DW-1:0] acc_o
);
   logic [REQ_DW-1:0]    src;
   logic [BUS_BYTES-1:0] base_mask;
   logic [BUS_DW-1:0]    picked;
   logic [BUS_DW-1:0]    keep;

   always_comb begin
      unique case (sz_i)
         2'd0:    base_mask = 4'b0001;
         2'd1:    base_mask = 4'b0011;
         default: base_mask = 4'b1111;
      endcase
   end

   assign src     = wdata_i >> {done_bytes_i, 3'b000};
   assign wdata_o = src[BUS_DW-1:0] << {lane_i, 3'b000};
   assign strb_o  = base_mask << lane_i;
   assign picked  = rdata_i >> {lane_i, 3'b000};

   for (genvar b = 0; b < BUS_BYTES; b++) begin : g_keep
      assign keep[8*b +: 8] = {8{base_mask[b]}};
   end

   assign acc_o = acc_i | ({{(REQ_DW-BUS_DW){1'b0}}, picked & keep} << {done_bytes_i, 3'b000});
endmodule

// File: rtl/uas_splitter.sv
module uas_splitter
   import uas_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter bit          WRAP_EN   = 1'b0,
   parameter int unsigned WRAP_BITS = 29
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic              req_priv,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [63:0]       req_wdata,
   output logic              rsp_done,
   output logic              rsp_fault,
   output logic [63:0]       rsp_rdata,
   output logic              bus_req,
   input  logic              bus_ack,
   input  logic              bus_err,
   output logic              bus_write,
   output logic [1:0]        bus_size,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [31:0]       bus_wdata,
   output logic [3:0]        bus_strb,
   input  logic [31:0]       bus_rdata
);
   if (ADDR_W < 8) begin : g_chk_addr
      $error("uas_splitter: ADDR_W must be at least 8");
   end
   if (WRAP_EN && (WRAP_BITS < 3 || WRAP_BITS > ADDR_W)) begin : g_chk_wrap
      $error("uas_splitter: WRAP_BITS must lie between 3 and ADDR_W");
   end

   typedef enum logic {ST_IDLE, ST_BUS} state_e;

   state_e                       state_q;
   logic [ADDR_W-1:0]            cur_addr_q;
   logic [1:0]                   part_idx_q;
   logic [1:0]                   nparts_q;
   logic [MAX_PARTS-1:0][1:0]    part_sz_q;
   logic [3:0]                   consumed_q;
   logic [REQ_DW-1:0]            wdata_q;
   logic [REQ_DW-1:0]            acc_q;
   logic                         write_q;

   logic                         plan_illegal;
   logic [1:0]                   plan_nparts;
   logic [MAX_PARTS-1:0][1:0]    plan_sz;
   logic [1:0]                   cur_sz;
   logic [ADDR_W-1:0]            nxt_addr;
   logic [REQ_DW-1:0]            acc_nxt;
   logic                         accept;
   logic                         hit;
   logic                         last_part;

   uas_planner u_plan (
      .size_i    (xfer_size_e'(req_size)),
      .off_i     (req_addr[1:0]),
      .priv_i    (req_priv),
      .illegal_o (plan_illegal),
      .nparts_o  (plan_nparts),
      .part_sz_o (plan_sz)
   );

   assign cur_sz = part_sz_q[part_idx_q];

   uas_addr_step #(
      .ADDR_W    (ADDR_W),
      .WRAP_EN   (WRAP_EN),
      .WRAP_BITS (WRAP_BITS)
   ) u_step (
      .addr_i (cur_addr_q),
      .sz_i   (cur_sz),
      .next_o (nxt_addr)
   );

   uas_lane_steer u_lanes (
      .lane_i       (cur_addr_q[1:0]),
      .sz_i         (cur_sz),
      .done_bytes_i (consumed_q[2:0]),
      .wdata_i      (wdata_q),
      .rdata_i      (bus_rdata),
      .acc_i        (acc_q),
      .wdata_o      (bus_wdata),
      .strb_o       (bus_strb),
      .acc_o        (acc_nxt)
   );

   assign req_ready = (state_q == ST_IDLE) && !rsp_done;
   assign accept    = req_valid && req_ready;
   assign bus_req   = (state_q == ST_BUS);
   assign bus_write = write_q;
   assign bus_size  = cur_sz;
   assign bus_addr  = cur_addr_q;
   assign hit       = bus_req && bus_ack;
   assign last_part = (part_idx_q == nparts_q - 2'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cur_addr_q <= '0;
         part_idx_q <= '0;
         nparts_q   <= 2'd1;
         part_sz_q  <= '0;
         consumed_q <= '0;
         wdata_q    <= '0;
         acc_q      <= '0;
         write_q    <= 1'b0;
         rsp_done   <= 1'b0;
         rsp_fault  <= 1'b0;
         rsp_rdata  <= '0;
      end else begin
         rsp_done  <= 1'b0;
         rsp_fault <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (plan_illegal) begin
                     rsp_done  <= 1'b1;
                     rsp_fault <= 1'b1;
                     rsp_rdata <= '0;
                  end else begin
                     state_q    <= ST_BUS;
                     cur_addr_q <= req_addr;
                     part_idx_q <= '0;
                     nparts_q   <= plan_nparts;
                     part_sz_q  <= plan_sz;
                     consumed_q <= '0;
                     wdata_q    <= req_wdata;
                     acc_q      <= '0;
                     write_q    <= req_write;
                  end
               end
            end
            default: begin
               if (hit) begin
                  if (bus_err) begin
                     state_q   <= ST_IDLE;
                     rsp_done  <= 1'b1;
                     rsp_fault <= 1'b1;
                     rsp_rdata <= '0;
                  end else begin
                     acc_q      <= acc_nxt;
                     consumed_q <= consumed_q + (4'd1 << cur_sz);
                     cur_addr_q <= nxt_addr;
                     part_idx_q <= part_idx_q + 2'd1;
                     if (last_part) begin
                        state_q   <= ST_IDLE;
                        rsp_done  <= 1'b1;
                        rsp_rdata <= acc_nxt;
                     end
                  end
               end
            end
         endcase
      end
   end

   p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_size != 2'd3) &&
                  ((bus_size == 2'd2) ? (bus_addr[1:0] == 2'b00) :
                   (bus_size == 2'd1) ? !bus_addr[0] : 1'b1));

   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_size) && $stable(bus_wdata));

   p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> !req_ready);

   p_strb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> $countones(bus_strb) == (1 << bus_size));

   // R5 and R6: rejected requests fault without a bus transfer
   p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
      accept && plan_illegal |=> rsp_done && rsp_fault && !bus_req);

   p_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack && bus_err |=> rsp_done && rsp_fault && !bus_req);

   p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
endmodule

// File: tb/uas_splitter_tb_top.sv
`timescale 1ns/1ps
module uas_splitter_tb_top;
   logic        clk;
   logic        rst_n;
   logic        req_valid_v [2];
   logic        req_ready_v [2];
   logic        req_write;
   logic [1:0]  req_size;
   logic        req_priv;
   logic [31:0] req_addr;
   logic [63:0] req_wdata;
   logic        rsp_done_v  [2];
   logic        rsp_fault_v [2];
   logic [63:0] rsp_rdata_v [2];
   logic        bus_req_v   [2];
   logic        bus_ack_v   [2];
   logic        bus_err_v   [2];
   logic        bus_write_v [2];
   logic [1:0]  bus_size_v  [2];
   logic [31:0] bus_addr_v  [2];
   logic [31:0] bus_wdata_v [2];
   logic [3:0]  bus_strb_v  [2];
   logic [31:0] bus_rdata_v [2];

   int checks = 0;
   int errors = 0;

   initial clk = 1'b0;
   always #2 clk = ~clk;

   uas_splitter #(.ADDR_W(32), .WRAP_EN(1'b0), .WRAP_BITS(29)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid_v[0]), .req_ready(req_ready_v[0]),
      .req_write(req_write), .req_size(req_size), .req_priv(req_priv),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done_v[0]), .rsp_fault(rsp_fault_v[0]), .rsp_rdata(rsp_rdata_v[0]),
      .bus_req(bus_req_v[0]), .bus_ack(bus_ack_v[0]), .bus_err(bus_err_v[0]),
      .bus_write(bus_write_v[0]), .bus_size(bus_size_v[0]), .bus_addr(bus_addr_v[0]),
      .bus_wdata(bus_wdata_v[0]), .bus_strb(bus_strb_v[0]), .bus_rdata(bus_rdata_v[0])
   );

   uas_splitter #(.ADDR_W(32), .WRAP_EN(1'b1), .WRAP_BITS(29)) dut_wrap_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid_v[1]), .req_ready(req_ready_v[1]),
      .req_write(req_write), .req_size(req_size), .req_priv(req_priv),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done_v[1]), .rsp_fault(rsp_fault_v[1]), .rsp_rdata(rsp_rdata_v[1]),
      .bus_req(bus_req_v[1]), .bus_ack(bus_ack_v[1]), .bus_err(bus_err_v[1]),
      .bus_write(bus_write_v[1]), .bus_size(bus_size_v[1]), .bus_addr(bus_addr_v[1]),
      .bus_wdata(bus_wdata_v[1]), .bus_strb(bus_strb_v[1]), .bus_rdata(bus_rdata_v[1])
   );

   task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] mem_b(logic [31:0] a);
      return {a[4:0], a[7:5]} ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h3C;
   endfunction

   function automatic logic [31:0] byte_addr(int p, logic [31:0] a, int k);
      if (p == 1) return {a[31:29], a[28:0] + 29'(k)};
      return a + 32'(k);
   endfunction

   task automatic run_req(int p, bit wr, logic [1:0] sz, logic [31:0] a, bit priv,
                          logic [63:0] wd, int err_part);
      int nbytes;
      int off;
      bit bad;
      string stag;
      string atag;
      int esz [3];
      int eoff [3];
      int n;
      int c;
      logic [63:0] exp_rd;
      nbytes = 1 << sz;
      off    = int'(a[1:0]);
      bad    = (sz == 2'd3 && off != 0) ||
               (priv && (sz == 2'd1 || sz == 2'd2) && (off % nbytes) != 0);
      stag   = (sz == 2'd0) ? "R1" : (sz == 2'd1) ? ((off % 2 != 0) ? "R3" : "R1") :
               (sz == 2'd2) ? ((off == 0) ? "R1" : "R4") : "R5";
      atag   = (p == 1) ? "R7" : "R8";
      n = 0;
      c = 0;
      while (c < nbytes) begin
         logic [31:0] ca;
         int r;
         int s;
         ca = byte_addr(p, a, c);
         r  = nbytes - c;
         if (r >= 4 && ca[1:0] == 2'b00) s = 4;
         else if (r >= 2 && !ca[0]) s = 2;
         else s = 1;
         esz[n]  = s;
         eoff[n] = c;
         c += s;
         n++;
      end
      exp_rd = '0;
      for (int k = 0; k < nbytes; k++) exp_rd[8*k +: 8] = mem_b(byte_addr(p, a, k));

      check(req_ready_v[p] == 1'b1, "R12", "ready before request", 64'(req_ready_v[p]), 64'd1);
      req_valid_v[p] = 1'b1;
      req_write = wr;
      req_size  = sz;
      req_addr  = a;
      req_priv  = priv;
      req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      req_valid_v[p] = 1'b0;

      if (bad) begin
         check(rsp_done_v[p] && rsp_fault_v[p] && !bus_req_v[p], priv ? "R6" : "R5",
               "reject done/fault/busreq", {61'd0, rsp_done_v[p], rsp_fault_v[p], bus_req_v[p]}, 64'd6);
         @(posedge clk);
         @(negedge clk);
         check(!rsp_done_v[p] && !bus_req_v[p], priv ? "R6" : "R5", "no transfer after reject",
               {62'd0, rsp_done_v[p], bus_req_v[p]}, 64'd0);
         return;
      end

      for (int i = 0; i < n; i++) begin
         logic [31:0] ea;
         logic [1:0]  ecode;
         logic [31:0] ew;
         logic [31:0] em;
         logic [3:0]  es;
         int waits;
         ea    = byte_addr(p, a, eoff[i]);
         ecode = (esz[i] == 4) ? 2'd2 : (esz[i] == 2) ? 2'd1 : 2'd0;
         check(bus_req_v[p] && !rsp_done_v[p], stag, "transfer pending",
               {62'd0, bus_req_v[p], rsp_done_v[p]}, 64'd2);
         check(bus_addr_v[p] == ea, atag, "part address", 64'(bus_addr_v[p]), 64'(ea));
         check(bus_size_v[p] == ecode, stag, "part size", 64'(bus_size_v[p]), 64'(ecode));
         check((ecode == 2'd2) ? (bus_addr_v[p][1:0] == 2'b00) :
               (ecode == 2'd1) ? !bus_addr_v[p][0] : 1'b1, "R2", "alignment",
               64'(bus_addr_v[p]), 64'(ea));
         check(bus_write_v[p] == wr, "R9", "direction", 64'(bus_write_v[p]), 64'(wr));
         if (wr) begin
            es = 4'(((1 << esz[i]) - 1) << ea[1:0]);
            ew = '0;
            em = '0;
            for (int j = 0; j < esz[i]; j++) begin
               int lane;
               lane = int'(ea[1:0]) + j;
               ew[8*lane +: 8] = wd[8*(eoff[i]+j) +: 8];
               em[8*lane +: 8] = 8'hFF;
            end
            check(bus_strb_v[p] == es, "R9", "strobe", 64'(bus_strb_v[p]), 64'(es));
            check((bus_wdata_v[p] & em) == ew, "R9", "write lanes",
                  64'(bus_wdata_v[p] & em), 64'(ew));
         end
         waits = int'($urandom % 3);
         for (int w = 0; w < waits; w++) begin
            bus_ack_v[p] = 1'b0;
            @(posedge clk);
            @(negedge clk);
            check(bus_req_v[p] && bus_addr_v[p] == ea && !req_ready_v[p], "R12",
                  "hold while waiting", 64'(bus_addr_v[p]), 64'(ea));
         end
         for (int l = 0; l < 4; l++) bus_rdata_v[p][8*l +: 8] = mem_b({bus_addr_v[p][31:2], 2'(l)});
         bus_ack_v[p] = 1'b1;
         bus_err_v[p] = (i == err_part);
         @(posedge clk);
         @(negedge clk);
         bus_ack_v[p] = 1'b0;
         bus_err_v[p] = 1'b0;
         if (i == err_part) begin
            check(rsp_done_v[p] && rsp_fault_v[p] && !bus_req_v[p], "R11", "error ends request",
                  {61'd0, rsp_done_v[p], rsp_fault_v[p], bus_req_v[p]}, 64'd6);
            @(posedge clk);
            @(negedge clk);
            check(!bus_req_v[p] && !rsp_done_v[p], "R11", "no parts after error",
                  {62'd0, bus_req_v[p], rsp_done_v[p]}, 64'd0);
            return;
         end
      end
      check(rsp_done_v[p] && !rsp_fault_v[p] && !bus_req_v[p], "R10", "done after last part",
            {61'd0, rsp_done_v[p], rsp_fault_v[p], bus_req_v[p]}, 64'd4);
      if (!wr) check(rsp_rdata_v[p] == exp_rd, "R10", "merged load data", rsp_rdata_v[p], exp_rd);
      @(posedge clk);
      @(negedge clk);
      check(!rsp_done_v[p], "R10", "done is one pulse", 64'(rsp_done_v[p]), 64'd0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      void'($urandom(32'd771));
      rst_n = 1'b0;
      req_write = 1'b0;
      req_size  = 2'd0;
      req_priv  = 1'b0;
      req_addr  = '0;
      req_wdata = '0;
      for (int p = 0; p < 2; p++) begin
         req_valid_v[p] = 1'b0;
         bus_ack_v[p]   = 1'b0;
         bus_err_v[p]   = 1'b0;
         bus_rdata_v[p] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int p = 0; p < 2; p++)
         check(req_ready_v[p] && !bus_req_v[p] && !rsp_done_v[p], "R13", "reset state",
               {61'd0, req_ready_v[p], bus_req_v[p], rsp_done_v[p]}, 64'd4);

      // directed corner cases
      run_req(0, 1'b0, 2'd1, 32'hDFFF_FFFF, 1'b0, 64'h0, -1);       // R8 run past limit
      run_req(0, 1'b1, 2'd1, 32'hFFFF_FFFF, 1'b0, 64'hBEEF, -1);    // R8 top of space
      run_req(1, 1'b0, 2'd1, 32'h1FFF_FFFF, 1'b0, 64'h0, -1);       // R7 wrap to base
      run_req(1, 1'b1, 2'd2, 32'h1FFF_FFFD, 1'b0, 64'hA1B2C3D4, -1);// R7 three pieces
      run_req(0, 1'b0, 2'd1, 32'h21FF_FFFF, 1'b0, 64'h0, -1);       // R8 alias crossing
      run_req(0, 1'b0, 2'd2, 32'hE000_0101, 1'b1, 64'h0, -1);       // R6 reject
      run_req(0, 1'b1, 2'd1, 32'hE000_0103, 1'b1, 64'h55, -1);      // R6 reject
      run_req(0, 1'b1, 2'd2, 32'hE000_0100, 1'b1, 64'h11223344, -1);// R6 aligned allowed
      run_req(0, 1'b1, 2'd3, 32'h2000_0002, 1'b0, 64'h1, -1);       // R5 reject
      run_req(1, 1'b1, 2'd3, 32'h2000_0008, 1'b0, 64'h0102030405060708, -1); // R5 two words
      run_req(0, 1'b0, 2'd3, 32'h1FFF_FFFC, 1'b0, 64'h0, -1);       // R5 load pair
      run_req(0, 1'b1, 2'd2, 32'h2000_0001, 1'b0, 64'hCAFEF00D, -1);// R4
      run_req(0, 1'b1, 2'd2, 32'h2000_0002, 1'b0, 64'hCAFEF00D, -1);// R4
      run_req(0, 1'b0, 2'd2, 32'h2000_0003, 1'b0, 64'h0, -1);       // R4
      run_req(0, 1'b0, 2'd2, 32'h2000_0001, 1'b0, 64'h0, 1);        // R11 middle part
      run_req(1, 1'b1, 2'd1, 32'h0000_0003, 1'b0, 64'h77, 0);       // R11 first part
      run_req(0, 1'b0, 2'd0, 32'h3000_0002, 1'b0, 64'h0, 0);        // R11 single part

      // constrained random mix
      for (int t = 0; t < 400; t++) begin
         int p;
         logic [31:0] a;
         bit priv;
         int ep;
         p = int'($urandom % 2);
         case ($urandom % 6)
            0: a = 32'h1FFF_FFFC;
            1: a = 32'hDFFF_FFFC;
            2: a = 32'hFFFF_FFFC;
            3: a = 32'h21FF_FFFC;
            4: a = 32'hE000_0000 + ($urandom & 32'h000F_FFFC);
            default: a = $urandom & 32'hFFFF_FFFC;
         endcase
         a[1:0] = 2'($urandom % 4);
         priv = (p == 0) && (a >= 32'hE000_0000) && (a <= 32'hE00F_FFFF);
         ep = ($urandom % 8 == 0) ? int'($urandom % 3) : -1;
         run_req(p, 1'($urandom % 2), 2'($urandom % 4), a, priv,
                 {$urandom, $urandom}, ep);
      end
      finish_run();
   end
endmodule